// File: doc/BRIEF.md
# Banked Event Interrupt Aggregator

This block gathers one-cycle event pulses from many sources into a small set of pending banks and turns them into a few level-sensitive interrupt lines. Each event carries an identifier: its upper bits pick a bank, its lower bits pick a bit inside that bank. A pending bit stays set until something clears it. Software clears it by writing ones over a register port. A source clears its own bit through a dedicated clear strobe.

Every interrupt line has its own mask per bank. A line is high while any bank holds a pending bit that the line's mask enables. Several lines can therefore watch the same events with different selections. One bit, bank 0 bit 0 by default, ignores software clears. Only its source's clear strobe can drop it. The output stage can be registered (the default) or combinational.

Top module: `evt_irq_agg`

## Requirements
- R1: While reset is asserted, and on release, every pending register and every mask register reads zero and all interrupt lines are low.
- R2: An event strobe with identifier `id` sets pending bit `id[4:0]` of bank `id[6:5]`. Bank value 3 selects no bank, and such an event changes no pending bit. No pending bit sets without an event for it.
- R3: With the default registered output, a line rises on the second clock edge after the event strobe is sampled. The pending bit is visible on reads after the first edge.
- R4: Line 0, line 1 and line 2 each use their own mask per bank. A pending bit enabled only in one line's mask raises only that line.
- R5: A write to a pending register clears exactly the bits written as one. Bits written as zero keep their value.
- R6: A software write never clears the protected bit, which is bank 0 bit 0 by default.
- R7: The clear strobe with identifier `id` clears the pending bit that an event with the same `id` would set. This includes the protected bit.
- R8: A line stays high while any bank still holds a pending bit enabled in that line's mask. It falls one cycle after the last such bit is cleared.
- R9: When an event and a clear (software write or clear strobe) hit the same bit in the same cycle, the bit ends set.
- R10: A mask write takes effect from the next cycle. Clearing a mask bit drops a line that depends only on it. Setting a mask bit over an already pending bit raises the line.
- R11: The register address is `{space[1:0], bank[1:0]}`. Space 0 is pending (read, write-1-to-clear), and spaces 1, 2, 3 are the read/write masks of lines 0, 1, 2. Bank field 3 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set_vld | input | 1 | Event strobe, one cycle per event |
| evt_set_id | input | 7 | Identifier of the event being raised |
| evt_clr_vld | input | 1 | Source clear strobe |
| evt_clr_id | input | 7 | Identifier of the pending bit to clear |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address `{space, bank}` |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| irq_out | output | 3 | Level interrupt lines, bit n is line n |

## Verification
The bench targets these corner cases:
- An all-ones clear over bank 0 leaves the protected bit standing. A design that masked the wrong bit, or none, would drop line 0 early.
- An event aimed at the nonexistent bank 3 leaves bank 0 unchanged. A design that truncated the bank field would set bank 0 bit 0 and raise line 0.
- An event meets a software clear, and then a clear strobe, on the same bit in the same cycle. A design that let the clear win would lose the interrupt.
- A line stays up while a second enabled bit remains pending. The bench also samples a line one cycle after the event, so an extra or missing register stage shows as a wrong level.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned DEF_BANKS     = 3;
   localparam int unsigned DEF_BANK_W    = 32;
   localparam int unsigned DEF_LINES     = 3;
   localparam int unsigned DEF_PROT_BANK = 0;
   localparam int unsigned DEF_PROT_BIT  = 0;

   // flat index of a bit inside the concatenated pending banks
   function automatic int unsigned flat_index(input int unsigned bank,
                                              input int unsigned bitpos,
                                              input int unsigned bank_w);
      return bank * bank_w + bitpos;
   endfunction
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned BANK_AW   = 2,
   parameter int unsigned BIT_AW    = 5,
   localparam int unsigned ID_W     = BANK_AW + BIT_AW,
   localparam int unsigned FLAT_W   = NUM_BANKS * BANK_W
) (
   input  logic              vld,
   input  logic [ID_W-1:0]   id,
   output logic [FLAT_W-1:0] vec
);
   logic [BANK_AW-1:0] bank_sel;
   logic [BIT_AW-1:0]  bit_sel;

   assign bank_sel = id[ID_W-1:BIT_AW];
   assign bit_sel  = id[BIT_AW-1:0];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign vec[b*BANK_W +: BANK_W] =
         (vld && bank_sel == BANK_AW'(b)) ? (BANK_W'(1) << bit_sel) : '0;
   end
endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
   parameter int unsigned      BANK_W    = 32,
   parameter logic [BANK_W-1:0] PROT_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] set_vec,
   input  logic [BANK_W-1:0] clr_vec,
   input  logic              sw_wr,
   input  logic [BANK_W-1:0] sw_data,
   output logic [BANK_W-1:0] pend
);
   logic [BANK_W-1:0] sw_clr;
   logic [BANK_W-1:0] pend_nxt;

   // software may not clear protected bits; set beats every clear
   assign sw_clr   = sw_wr ? (sw_data & ~PROT_MASK) : '0;
   assign pend_nxt = (pend & ~(sw_clr | clr_vec)) | set_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned NUM_LINES = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned BANK_AW   = 2,
   parameter int unsigned SEL_AW    = 2,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned FLAT_W   = NUM_BANKS * BANK_W,
   localparam int unsigned MASK_W   = NUM_LINES * FLAT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [SEL_AW-1:0]    sel,
   input  logic [BANK_AW-1:0]   bank,
   input  logic [BANK_W-1:0]    wdata,
   input  logic [FLAT_W-1:0]    pend_flat,
   output logic [MASK_W-1:0]    mask_flat,
   output logic [NUM_LINES-1:0] irq
);
   logic [NUM_LINES-1:0] hit;

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mask_flat[(l*NUM_BANKS+b)*BANK_W +: BANK_W] <= '0;
            else if (wr && sel == SEL_AW'(l+1) && bank == BANK_AW'(b))
               mask_flat[(l*NUM_BANKS+b)*BANK_W +: BANK_W] <= wdata;
         end
      end

      always_comb begin
         logic [BANK_W-1:0] acc;
         acc = '0;
         for (int b = 0; b < NUM_BANKS; b++)
            acc |= pend_flat[b*BANK_W +: BANK_W]
                 & mask_flat[(l*NUM_BANKS+b)*BANK_W +: BANK_W];
         hit[l] = |acc;
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= '0;
         else        irq <= hit;
      end
   end else begin : g_out_comb
      assign irq = hit;
   end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS = DEF_BANKS,
   parameter int unsigned BANK_W    = DEF_BANK_W,
   parameter int unsigned NUM_LINES = DEF_LINES,
   parameter int unsigned PROT_BANK = DEF_PROT_BANK,
   parameter int unsigned PROT_BIT  = DEF_PROT_BIT,
   parameter bit          OUT_REG   = 1'b1,
   localparam int unsigned BANK_AW  = $clog2(NUM_BANKS),
   localparam int unsigned BIT_AW   = $clog2(BANK_W),
   localparam int unsigned SEL_AW   = $clog2(NUM_LINES + 1),
   localparam int unsigned ID_W     = BANK_AW + BIT_AW,
   localparam int unsigned ADDR_W   = SEL_AW + BANK_AW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 evt_set_vld,
   input  logic [ID_W-1:0]      evt_set_id,
   input  logic                 evt_clr_vld,
   input  logic [ID_W-1:0]      evt_clr_id,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [BANK_W-1:0]    reg_wdata,
   output logic [BANK_W-1:0]    reg_rdata,
   output logic [NUM_LINES-1:0] irq_out
);
   localparam int unsigned FLAT_W = NUM_BANKS * BANK_W;
   localparam int unsigned MASK_W = NUM_LINES * FLAT_W;

   if (NUM_BANKS < 2 || NUM_BANKS > 4) begin : g_chk_banks
      $error("NUM_BANKS must lie in 2..4");
   end
   if (BANK_W < 2 || (1 << BIT_AW) != BANK_W) begin : g_chk_width
      $error("BANK_W must be a power of two");
   end
   if (NUM_LINES < 1) begin : g_chk_lines
      $error("NUM_LINES must be at least 1");
   end
   if (PROT_BANK >= NUM_BANKS || PROT_BIT >= BANK_W) begin : g_chk_prot
      $error("protected bit outside the pending banks");
   end

   logic [SEL_AW-1:0]  sel;
   logic [BANK_AW-1:0] bank;
   logic [FLAT_W-1:0]  set_flat;
   logic [FLAT_W-1:0]  clr_flat;
   logic [FLAT_W-1:0]  pend_flat;
   logic [MASK_W-1:0]  mask_flat;

   assign sel  = reg_addr[ADDR_W-1:BANK_AW];
   assign bank = reg_addr[BANK_AW-1:0];

   evt_irq_decode #(
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BANK_AW(BANK_AW), .BIT_AW(BIT_AW)
   ) u_set_dec (
      .vld(evt_set_vld), .id(evt_set_id), .vec(set_flat)
   );

   evt_irq_decode #(
      .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .BANK_AW(BANK_AW), .BIT_AW(BIT_AW)
   ) u_clr_dec (
      .vld(evt_clr_vld), .id(evt_clr_id), .vec(clr_flat)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pend
      localparam logic [BANK_W-1:0] PMASK =
         (b == PROT_BANK) ? (BANK_W'(1) << PROT_BIT) : '0;
      evt_irq_bank #(.BANK_W(BANK_W), .PROT_MASK(PMASK)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_vec(set_flat[b*BANK_W +: BANK_W]),
         .clr_vec(clr_flat[b*BANK_W +: BANK_W]),
         .sw_wr  (reg_wr && sel == '0 && bank == BANK_AW'(b)),
         .sw_data(reg_wdata),
         .pend   (pend_flat[b*BANK_W +: BANK_W])
      );
   end

   evt_irq_route #(
      .NUM_BANKS(NUM_BANKS), .NUM_LINES(NUM_LINES), .BANK_W(BANK_W),
      .BANK_AW(BANK_AW), .SEL_AW(SEL_AW), .OUT_REG(OUT_REG)
   ) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .sel      (sel),
      .bank     (bank),
      .wdata    (reg_wdata),
      .pend_flat(pend_flat),
      .mask_flat(mask_flat),
      .irq      (irq_out)
   );

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank == BANK_AW'(b)) begin
            if (sel == '0) reg_rdata = pend_flat[b*BANK_W +: BANK_W];
            for (int l = 0; l < NUM_LINES; l++)
               if (sel == SEL_AW'(l+1))
                  reg_rdata = mask_flat[(l*NUM_BANKS+b)*BANK_W +: BANK_W];
         end
      end
   end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned NUM_LINES = 3,
   parameter int unsigned PROT_BANK = 0,
   parameter int unsigned PROT_BIT  = 0,
   parameter bit          OUT_REG   = 1'b1,
   parameter int unsigned BANK_AW   = 2,
   parameter int unsigned BIT_AW    = 5,
   localparam int unsigned ID_W     = BANK_AW + BIT_AW,
   localparam int unsigned FLAT_W   = NUM_BANKS * BANK_W,
   localparam int unsigned MASK_W   = NUM_LINES * FLAT_W,
   localparam int unsigned PROT_IDX = PROT_BANK * BANK_W + PROT_BIT
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 evt_set_vld,
   input logic [ID_W-1:0]      evt_set_id,
   input logic                 evt_clr_vld,
   input logic [ID_W-1:0]      evt_clr_id,
   input logic [BANK_AW-1:0]   rd_bank,
   input logic [BANK_W-1:0]    reg_rdata,
   input logic [NUM_LINES-1:0] irq_out,
   input logic [FLAT_W-1:0]    pend_flat,
   input logic [MASK_W-1:0]    mask_flat
);
   logic [FLAT_W-1:0]    ev_vec;
   logic [NUM_LINES-1:0] hit;
   logic                 past_ok;

   always_comb begin
      ev_vec = '0;
      if (evt_set_vld && int'(evt_set_id[ID_W-1:BIT_AW]) < NUM_BANKS)
         ev_vec[int'(evt_set_id[ID_W-1:BIT_AW]) * BANK_W
                + int'(evt_set_id[BIT_AW-1:0])] = 1'b1;
   end

   always_comb begin
      hit = '0;
      for (int l = 0; l < NUM_LINES; l++)
         for (int i = 0; i < FLAT_W; i++)
            if (pend_flat[i] && mask_flat[l*FLAT_W + i]) hit[l] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_EVENT_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_vec) |=> ((pend_flat & $past(ev_vec)) == $past(ev_vec))); // R9

   AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((pend_flat & ~$past(pend_flat) & ~$past(ev_vec)) == '0)); // R2

   AST_PROT_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flat[PROT_IDX] &&
       !(evt_clr_vld && int'(evt_clr_id[ID_W-1:BIT_AW]) == PROT_BANK
                     && int'(evt_clr_id[BIT_AW-1:0]) == PROT_BIT))
      |=> pend_flat[PROT_IDX]); // R6

   if (OUT_REG) begin : g_reg
      AST_LINE_TRACKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (irq_out == $past(hit))); // R8
   end else begin : g_comb
      AST_LINE_TRACKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out == hit); // R8
   end

   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_bank) >= NUM_BANKS) |-> (reg_rdata == '0)); // R11
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
   .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .NUM_LINES(NUM_LINES),
   .PROT_BANK(PROT_BANK), .PROT_BIT(PROT_BIT), .OUT_REG(OUT_REG),
   .BANK_AW(BANK_AW), .BIT_AW(BIT_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_set_vld(evt_set_vld),
   .evt_set_id (evt_set_id),
   .evt_clr_vld(evt_clr_vld),
   .evt_clr_id (evt_clr_id),
   .rd_bank    (bank),
   .reg_rdata  (reg_rdata),
   .irq_out    (irq_out),
   .pend_flat  (pend_flat),
   .mask_flat  (mask_flat)
);

// File: tb/evt_irq_agg_tb_top.sv
module evt_irq_agg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_set_vld = 1'b0;
   logic [6:0]  evt_set_id = '0;
   logic        evt_clr_vld = 1'b0;
   logic [6:0]  evt_clr_id = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [2:0]  irq_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   evt_irq_agg dut_i (
      .clk(clk), .rst_n(rst_n),
      .evt_set_vld(evt_set_vld), .evt_set_id(evt_set_id),
      .evt_clr_vld(evt_clr_vld), .evt_clr_id(evt_clr_id),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   typedef struct packed {
      logic        ev_v;
      logic [6:0]  ev_id;
      logic        cl_v;
      logic [6:0]  cl_id;
      logic        wr;
      logic [3:0]  addr;
      logic [31:0] wdata;
      logic [3:0]  rd_addr;
      logic [31:0] exp_rd;
      logic [2:0]  exp_irq;
      int          req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{0, 7'h00, 0, 7'h00, 1, 4'd4,  32'h0000_0001, 4'd4,  32'h0000_0001, 3'b000, 11}, // R11 mask A bank0
      '{0, 7'h00, 0, 7'h00, 1, 4'd9,  32'h8000_0000, 4'd9,  32'h8000_0000, 3'b000, 11}, // R11 mask B bank1
      '{0, 7'h00, 0, 7'h00, 1, 4'd14, 32'h0000_0010, 4'd14, 32'h0000_0010, 3'b000, 11}, // R11 mask C bank2
      '{1, 7'h3F, 0, 7'h00, 0, 4'd0,  32'h0,         4'd1,  32'h8000_0000, 3'b010, 2},  // R2 bank1 bit31
      '{1, 7'h44, 0, 7'h00, 0, 4'd0,  32'h0,         4'd2,  32'h0000_0010, 3'b110, 4},  // R4 line 2 only
      '{1, 7'h00, 0, 7'h00, 0, 4'd0,  32'h0,         4'd0,  32'h0000_0001, 3'b111, 3},  // R3
      '{1, 7'h05, 0, 7'h00, 0, 4'd0,  32'h0,         4'd0,  32'h0000_0021, 3'b111, 2},  // R2 unmasked bit
      '{0, 7'h00, 0, 7'h00, 1, 4'd0,  32'hFFFF_FFFF, 4'd0,  32'h0000_0001, 3'b111, 6},  // R6 protected
      '{0, 7'h00, 1, 7'h00, 0, 4'd0,  32'h0,         4'd0,  32'h0000_0000, 3'b110, 7},  // R7 clear strobe
      '{0, 7'h00, 0, 7'h00, 1, 4'd1,  32'h7FFF_FFFF, 4'd1,  32'h8000_0000, 3'b110, 5},  // R5 zeros keep
      '{0, 7'h00, 0, 7'h00, 1, 4'd1,  32'h8000_0000, 4'd1,  32'h0000_0000, 3'b100, 8},  // R8 line 1 drops
      '{0, 7'h00, 0, 7'h00, 1, 4'd14, 32'h0000_0000, 4'd2,  32'h0000_0010, 3'b000, 10}, // R10 mask off
      '{0, 7'h00, 0, 7'h00, 1, 4'd14, 32'h0000_0010, 4'd14, 32'h0000_0010, 3'b100, 10}, // R10 mask on
      '{1, 7'h44, 0, 7'h00, 1, 4'd2,  32'h0000_0010, 4'd2,  32'h0000_0010, 3'b100, 9},  // R9 vs write
      '{1, 7'h44, 1, 7'h44, 0, 4'd0,  32'h0,         4'd2,  32'h0000_0010, 3'b100, 9},  // R9 vs strobe
      '{1, 7'h60, 0, 7'h00, 0, 4'd0,  32'h0,         4'd0,  32'h0000_0000, 3'b100, 2},  // R2 bank 3 event
      '{0, 7'h00, 0, 7'h00, 1, 4'd7,  32'h0000_FFFF, 4'd7,  32'h0000_0000, 3'b100, 11}, // R11 bank 3 write
      '{0, 7'h00, 1, 7'h44, 0, 4'd0,  32'h0,         4'd2,  32'h0000_0000, 3'b000, 8},  // R8 last bit gone
      '{1, 7'h22, 0, 7'h00, 1, 4'd5,  32'h0000_0004, 4'd1,  32'h0000_0004, 3'b001, 3},  // R3 same-cycle mask
      '{0, 7'h00, 0, 7'h00, 1, 4'd12, 32'h0000_0004, 4'd12, 32'h0000_0004, 3'b001, 4},  // R4 other bank
      '{1, 7'h3F, 0, 7'h00, 0, 4'd0,  32'h0,         4'd1,  32'h8000_0004, 3'b011, 4},  // R4 two lines
      '{0, 7'h00, 1, 7'h22, 0, 4'd0,  32'h0,         4'd1,  32'h8000_0000, 3'b010, 8}   // R8 one remains
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   task automatic apply(input vec_t v);
      evt_set_vld = v.ev_v;  evt_set_id = v.ev_id;
      evt_clr_vld = v.cl_v;  evt_clr_id = v.cl_id;
      reg_wr = v.wr; reg_addr = v.addr; reg_wdata = v.wdata;
      @(posedge clk); #1;
      evt_set_vld = 1'b0; evt_clr_vld = 1'b0; reg_wr = 1'b0;
      reg_addr = v.rd_addr;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 during reset
      repeat (3) @(posedge clk);
      #1;
      check("R1 irq in reset", 32'(irq_out), 32'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      for (int a = 0; a < 16; a++) begin
         reg_addr = 4'(a);
         #1;
         check($sformatf("R1 reg %0d after reset", a), reg_rdata, 32'h0);
      end
      check("R1 irq after reset", 32'(irq_out), 32'h0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), reg_rdata, VEC[i].exp_rd);
         check($sformatf("R%0d vec %0d irq", VEC[i].req, i), 32'(irq_out), 32'(VEC[i].exp_irq));
      end

      // R3: line 0 must rise on the second edge, not the first
      evt_set_vld = 1'b1; evt_set_id = 7'h00; reg_addr = 4'd0;
      @(posedge clk); #1;
      evt_set_vld = 1'b0;
      check("R3 pending after first edge", reg_rdata, 32'h1);
      check("R3 line 0 still low after first edge", 32'(irq_out), 32'b010);
      @(posedge clk); #1;
      check("R3 line 0 high after second edge", 32'(irq_out), 32'b011);

      // R1 reset mid-run wipes pending and masks
      rst_n = 1'b0;
      #1;
      check("R1 irq under mid-run reset", 32'(irq_out), 32'h0);
      reg_addr = 4'd1; #1;
      check("R1 pending bank1 under reset", reg_rdata, 32'h0);
      reg_addr = 4'd4; #1;
      check("R1 mask A bank0 under reset", reg_rdata, 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 irq after reset release", 32'(irq_out), 32'h0);

      finish_run();
   end
endmodule